// File: doc/BRIEF.md
# Texture Bilerp Slot Scheduler

This block sits between the texture address stage of one shader cluster and its pool of bilinear-interpolation (bilerp) units. Each clock it sees up to four pending pixel fetch requests, in arrival order, on parallel lanes. Every request is priced in INT8-bilerp units according to its texel format and filter mode. The block grants as many requests as fit into the pool's per-cycle budget, which defaults to eight units. Each granted request is then expanded into that many bilerp operations. The operations are packed into the output slots one clock later, and each one carries its pixel id and its sub-bilerp index.

The upstream stage keeps its oldest requests on lane 0 upward. It reads the grant count and drops that many requests from the front of its queue. A request that costs more than the whole budget can only arise with a budget below eight. Such a request is granted alone and streamed over several clocks, and the input is held off until its last portion has gone out. The interpolation arithmetic, the texel memory and the caches are not part of this block.

Top module: `tex_bilerp_sched`

## Requirements
- R1: After reset no output slot is valid, `in_ready` is 1 and `in_take_cnt` is 0 while no lane is valid.
- R2: Request cost in units: format code 0 (8-bit) costs 1, code 1 (half float) costs 2, and codes 2 and 3 (single float) cost 4. The cost is doubled when the anisotropic bit is set, so the set of costs is 1, 2, 4 and 8.
- R3: Grants are in lane order. Lanes are considered from lane 0 upward, and the first valid lane whose cost does not fit into the units left this clock stops granting for itself and for every later lane, even when a later lane would fit.
- R4: The valid output slots of one clock form a contiguous run starting at slot 0. They are filled in grant order and number at most BUDGET.
- R5: The operations of requests granted in clock t appear on the slot outputs in clock t+1.
- R6: A request of cost c occupies c adjacent slots. Each of them carries the request's pixel id, and the sub-bilerp indices run 0 to c-1 in ascending slot order.
- R7: At most LANES requests are granted per clock, even when budget is left over. For example, four 8-bit bilinear requests use only 4 of the 8 units.
- R8: A request costing more than BUDGET is granted only when it sits on lane 0. It then issues BUDGET operations per clock, with sub indices continuing across clocks. `in_ready` is 0 and `in_take_cnt` is 0 in every following clock until its last portion is issued. Granting resumes on the clock after the last portion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Lane holds a pending request (valid lanes form a prefix from lane 0) |
| in_fmt | input | 2*LANES | Texel format code per lane |
| in_aniso | input | LANES | Anisotropic 2x filter select per lane |
| in_pix | input | LANES*PIXW | Pixel id per lane |
| in_ready | output | 1 | Low while a spread request is still being issued |
| in_take_cnt | output | $clog2(LANES+1) | Number of lanes granted this clock, counted from lane 0 |
| slot_vld | output | BUDGET | Valid flag per bilerp slot |
| slot_pix | output | BUDGET*PIXW | Pixel id per slot |
| slot_sub | output | BUDGET*3 | Sub-bilerp index per slot |

## Verification
The assertions assume that valid lanes form an unbroken run from lane 0. They also assume that a request stays on its lane, moving down only as earlier lanes are granted, until the block counts it in `in_take_cnt`. The bench meets both assumptions by driving the lanes straight from the head of one in-order queue and popping exactly the granted count after each clock. The assertions further assume that reset is held from time zero through the first clock edges, and the bench does so. The random phase mixes all eight format and filter combinations with partly filled lane sets, so no lane is ever valid above an invalid one.

// File: rtl/tex_rate_pkg.sv
package tex_rate_pkg;

  localparam int MAX_COST = 8;
  localparam int COST_W   = 4;
  localparam int SUB_W    = 3;

  typedef enum logic [1:0] {
    TF_UNORM8    = 2'd0,
    TF_HALF      = 2'd1,
    TF_FLOAT     = 2'd2,
    TF_FLOAT_ALT = 2'd3
  } tex_fmt_e;

  // Price of one request in 8-bit bilerp units (R2).
  function automatic logic [COST_W-1:0] bilerp_cost(input logic [1:0] fmt,
                                                    input logic aniso);
    logic [COST_W-1:0] unit;
    case (tex_fmt_e'(fmt))
      TF_UNORM8: unit = 4'd1;
      TF_HALF:   unit = 4'd2;
      default:   unit = 4'd4;
    endcase
    bilerp_cost = aniso ? (unit << 1) : unit;
  endfunction

endpackage

// File: rtl/trs_lane_cost.sv
module trs_lane_cost
  import tex_rate_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0]      fmt,
  input  logic [LANES-1:0]        aniso,
  output logic [LANES*COST_W-1:0] cost
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cost[i*COST_W +: COST_W] = bilerp_cost(fmt[2*i +: 2], aniso[i]);
  end

endmodule

// File: rtl/trs_accept.sv
module trs_accept
  import tex_rate_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BUDGET = 8,
  parameter int SUM_W  = 6,
  parameter int TAKE_W = 3
) (
  input  logic                    blocked,
  input  logic [LANES-1:0]        valid,
  input  logic [LANES*COST_W-1:0] cost,
  output logic [LANES-1:0]        take,
  output logic [LANES*SUM_W-1:0]  base,
  output logic                    split,
  output logic [TAKE_W-1:0]       take_cnt
);

  localparam logic [SUM_W-1:0] BUD_S = SUM_W'(BUDGET);

  // In-order walk over the lanes; the first misfit stops the walk (R3).
  always_comb begin
    logic [SUM_W-1:0] used;
    logic [SUM_W-1:0] c;
    logic             stop;
    used     = '0;
    stop     = blocked;
    take     = '0;
    base     = '0;
    split    = 1'b0;
    take_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      c = SUM_W'(cost[i*COST_W +: COST_W]);
      base[i*SUM_W +: SUM_W] = used;
      if (!stop && valid[i]) begin
        if (used + c <= BUD_S) begin
          take[i]  = 1'b1;
          used     = used + c;
          take_cnt = take_cnt + TAKE_W'(1);
        end else if (used == '0) begin
          take[i]  = 1'b1;
          split    = 1'b1;
          used     = BUD_S;
          stop     = 1'b1;
          take_cnt = take_cnt + TAKE_W'(1);
        end else begin
          stop = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
  end

endmodule

// File: rtl/trs_slot_pack.sv
module trs_slot_pack
  import tex_rate_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BUDGET = 8,
  parameter int PIXW   = 8,
  parameter int SUM_W  = 6
) (
  input  logic [LANES-1:0]        seg_en,
  input  logic [LANES*SUM_W-1:0]  seg_base,
  input  logic [LANES*COST_W-1:0] seg_len,
  input  logic [LANES*PIXW-1:0]   seg_pix,
  input  logic [LANES*SUB_W-1:0]  seg_sub0,
  output logic [BUDGET-1:0]       vld,
  output logic [BUDGET*PIXW-1:0]  pix,
  output logic [BUDGET*SUB_W-1:0] sub
);

  for (genvar s = 0; s < BUDGET; s++) begin : g_slot
    logic             v;
    logic [PIXW-1:0]  p;
    logic [SUB_W-1:0] sb;

    always_comb begin
      logic [SUM_W-1:0] lo;
      logic [SUM_W-1:0] hi;
      logic [SUM_W-1:0] here;
      here = SUM_W'(s);
      v  = 1'b0;
      p  = '0;
      sb = '0;
      for (int i = 0; i < LANES; i++) begin
        lo = seg_base[i*SUM_W +: SUM_W];
        hi = lo + SUM_W'(seg_len[i*COST_W +: COST_W]);
        if (seg_en[i] && here >= lo && here < hi) begin
          v  = 1'b1;
          p  = seg_pix[i*PIXW +: PIXW];
          sb = seg_sub0[i*SUB_W +: SUB_W] + SUB_W'(here - lo);
        end
      end
    end

    assign vld[s]                = v;
    assign pix[s*PIXW +: PIXW]   = p;
    assign sub[s*SUB_W +: SUB_W] = sb;
  end

endmodule

// File: rtl/tex_bilerp_sched.sv
module tex_bilerp_sched
  import tex_rate_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BUDGET = 8,
  parameter int PIXW   = 8,
  localparam int TAKE_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        in_valid,
  input  logic [2*LANES-1:0]      in_fmt,
  input  logic [LANES-1:0]        in_aniso,
  input  logic [LANES*PIXW-1:0]   in_pix,
  output logic                    in_ready,
  output logic [TAKE_W-1:0]       in_take_cnt,
  output logic [BUDGET-1:0]       slot_vld,
  output logic [BUDGET*PIXW-1:0]  slot_pix,
  output logic [BUDGET*SUB_W-1:0] slot_sub
);

  localparam int SUM_W = $clog2(LANES * MAX_COST + BUDGET + 1);
  localparam logic [COST_W-1:0] BUD_C = COST_W'(BUDGET);

  logic [LANES*COST_W-1:0] lane_cost;
  logic [LANES-1:0]        take;
  logic [LANES*SUM_W-1:0]  base;
  logic                    split;
  logic [TAKE_W-1:0]       take_cnt;

  // Spread-request state
  logic              busy_q;
  logic [COST_W-1:0] rem_q;
  logic [SUB_W-1:0]  off_q;
  logic [PIXW-1:0]   hpix_q;
  logic [COST_W-1:0] hold_len;

  // Named internal events
  logic split_start;
  logic spill_last;

  logic [LANES-1:0]        seg_en;
  logic [LANES*SUM_W-1:0]  seg_base;
  logic [LANES*COST_W-1:0] seg_len;
  logic [LANES*PIXW-1:0]   seg_pix;
  logic [LANES*SUB_W-1:0]  seg_sub0;

  logic [BUDGET-1:0]       pk_vld;
  logic [BUDGET*PIXW-1:0]  pk_pix;
  logic [BUDGET*SUB_W-1:0] pk_sub;

  trs_lane_cost #(.LANES(LANES)) u_cost (
    .fmt   (in_fmt),
    .aniso (in_aniso),
    .cost  (lane_cost)
  );

  trs_accept #(
    .LANES(LANES), .BUDGET(BUDGET), .SUM_W(SUM_W), .TAKE_W(TAKE_W)
  ) u_accept (
    .blocked  (busy_q),
    .valid    (in_valid),
    .cost     (lane_cost),
    .take     (take),
    .base     (base),
    .split    (split),
    .take_cnt (take_cnt)
  );

  assign hold_len    = (rem_q > BUD_C) ? BUD_C : rem_q;
  assign split_start = !busy_q && split;
  assign spill_last  = busy_q && (rem_q <= BUD_C);
  assign in_ready    = !busy_q;
  assign in_take_cnt = take_cnt;

  // Segment list: the held request alone while spreading, else the grants.
  always_comb begin
    seg_en   = take;
    seg_base = base;
    seg_len  = lane_cost;
    seg_pix  = in_pix;
    seg_sub0 = '0;
    if (busy_q) begin
      seg_en                 = '0;
      seg_en[0]              = 1'b1;
      seg_base               = '0;
      seg_len[0 +: COST_W]   = hold_len;
      seg_pix[0 +: PIXW]     = hpix_q;
      seg_sub0[0 +: SUB_W]   = off_q;
    end else if (split) begin
      seg_len[0 +: COST_W]   = BUD_C;
    end
  end

  trs_slot_pack #(
    .LANES(LANES), .BUDGET(BUDGET), .PIXW(PIXW), .SUM_W(SUM_W)
  ) u_pack (
    .seg_en   (seg_en),
    .seg_base (seg_base),
    .seg_len  (seg_len),
    .seg_pix  (seg_pix),
    .seg_sub0 (seg_sub0),
    .vld      (pk_vld),
    .pix      (pk_pix),
    .sub      (pk_sub)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rem_q    <= '0;
      off_q    <= '0;
      hpix_q   <= '0;
      slot_vld <= '0;
      slot_pix <= '0;
      slot_sub <= '0;
    end else begin
      slot_vld <= pk_vld;
      slot_pix <= pk_pix;
      slot_sub <= pk_sub;
      if (busy_q) begin
        rem_q  <= rem_q - hold_len;
        off_q  <= off_q + SUB_W'(hold_len);
        busy_q <= !spill_last;
      end else if (split_start) begin
        busy_q <= 1'b1;
        rem_q  <= lane_cost[0 +: COST_W] - BUD_C;
        off_q  <= SUB_W'(BUDGET);
        hpix_q <= in_pix[0 +: PIXW];
      end
    end
  end

  // Grants stay frozen while a spread request is streaming (R8)
  p_hold_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> in_take_cnt == '0);

  // Final portion releases the input on the next clock (R8)
  p_spill_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spill_last |=> in_ready);

  // An oversize grant blocks the input on the next clock (R8)
  p_split_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> !in_ready);

  // A grant shows up in slot 0 one clock later (R5)
  p_issue_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take_cnt != '0) |=> slot_vld[0]);

  // Valid slots are a contiguous run from slot 0 (R4)
  p_slots_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_vld + {{(BUDGET-1){1'b0}}, 1'b1}));

  // Granted lanes form a prefix (R3)
  p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take + {{(LANES-1){1'b0}}, 1'b1}));

endmodule

// File: tb/sim_tex_bilerp_sched.sv
module sim_tex_bilerp_sched;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  // Instance u0: default budget of 8
  logic [3:0]  a_valid, a_aniso;
  logic [7:0]  a_fmt;
  logic [31:0] a_pix;
  logic        a_ready;
  logic [2:0]  a_take;
  logic [7:0]  a_svld;
  logic [63:0] a_spix;
  logic [23:0] a_ssub;

  // Instance u1: budget of 4, so an 8-unit request must spread
  logic [3:0]  b_valid, b_aniso;
  logic [7:0]  b_fmt;
  logic [31:0] b_pix;
  logic        b_ready;
  logic [2:0]  b_take;
  logic [3:0]  b_svld;
  logic [31:0] b_spix;
  logic [11:0] b_ssub;

  tex_bilerp_sched u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_fmt(a_fmt),
    .in_aniso(a_aniso), .in_pix(a_pix), .in_ready(a_ready),
    .in_take_cnt(a_take), .slot_vld(a_svld), .slot_pix(a_spix),
    .slot_sub(a_ssub)
  );

  tex_bilerp_sched #(.BUDGET(4)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_fmt(b_fmt),
    .in_aniso(b_aniso), .in_pix(b_pix), .in_ready(b_ready),
    .in_take_cnt(b_take), .slot_vld(b_svld), .slot_pix(b_spix),
    .slot_sub(b_ssub)
  );

  typedef struct packed {
    logic [1:0] fmt;
    logic       an;
    logic [7:0] pix;
  } req_t;

  typedef struct packed {
    logic [7:0]  vld;
    logic [63:0] pix;
    logic [23:0] sub;
  } frame_t;

  req_t   req_q[$];
  frame_t exp_q[$];
  int     checks = 0;
  int     fails  = 0;
  bit     mon_on = 1'b0;
  bit     done   = 1'b0;

  // Bench-side price list, written as a product of two factors (R2)
  function automatic int price(input logic [1:0] f, input logic an);
    int fmt_mult;
    if (f == 2'd0)      fmt_mult = 1;
    else if (f == 2'd1) fmt_mult = 2;
    else                fmt_mult = 4;
    return fmt_mult * (an ? 2 : 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Driver: present the queue head, predict grants, push expected frame
  task automatic step(input string tag);
    int     used;
    int     n;
    int     c;
    frame_t fr;
    @(negedge clk);
    a_valid = '0; a_fmt = '0; a_aniso = '0; a_pix = '0;
    for (int i = 0; i < 4 && i < req_q.size(); i++) begin
      a_valid[i]         = 1'b1;
      a_fmt[2*i +: 2]    = req_q[i].fmt;
      a_aniso[i]         = req_q[i].an;
      a_pix[8*i +: 8]    = req_q[i].pix;
    end
    #1;
    fr = '0; used = 0; n = 0;
    for (int i = 0; i < 4 && i < req_q.size(); i++) begin
      c = price(req_q[i].fmt, req_q[i].an);
      if (used + c > 8) break;
      for (int k = 0; k < c; k++) begin
        fr.vld[used+k]          = 1'b1;
        fr.pix[(used+k)*8 +: 8] = req_q[i].pix;
        fr.sub[(used+k)*3 +: 3] = 3'(k);
      end
      used += c;
      n++;
    end
    chk(a_take == 3'(n), tag, "grant count", 64'(a_take), 64'(n));
    exp_q.push_back(fr);
    repeat (n) void'(req_q.pop_front());
  endtask

  // Monitor: compare the slots produced one clock after each grant (R5)
  frame_t      mon_e;
  logic [63:0] pm;
  logic [23:0] sm;
  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      pm = '0; sm = '0;
      for (int s = 0; s < 8; s++) begin
        if (mon_e.vld[s]) begin
          pm[s*8 +: 8] = 8'hFF;
          sm[s*3 +: 3] = 3'h7;
        end
      end
      chk(a_svld == mon_e.vld, "R4", "slot valid", 64'(a_svld), 64'(mon_e.vld));
      chk((a_spix & pm) == mon_e.pix, "R6", "slot pixel ids",
          a_spix & pm, mon_e.pix);
      chk((a_ssub & sm) == mon_e.sub, "R6", "slot sub indices",
          64'(a_ssub & sm), 64'(mon_e.sub));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    req_t r;
    a_valid = '0; a_fmt = '0; a_aniso = '0; a_pix = '0;
    b_valid = '0; b_fmt = '0; b_aniso = '0; b_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(a_svld == '0, "R1", "slot valid after reset", 64'(a_svld), 0);
    chk(a_ready == 1'b1, "R1", "ready after reset", 64'(a_ready), 1);
    chk(a_take == '0, "R1", "grant count after reset", 64'(a_take), 0);
    chk(b_ready == 1'b1, "R1", "ready after reset (budget 4)", 64'(b_ready), 1);
    mon_on = 1'b1;

    // R7: six cheap requests, only four lanes per clock
    for (int i = 0; i < 6; i++) req_q.push_back('{fmt: 2'd0, an: 1'b0, pix: 8'(1 + i)});
    step("R7");
    step("R7");
    step("R7");

    // R2: every format and filter combination, including code 3
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 2; a++)
        req_q.push_back('{fmt: 2'(f), an: a[0], pix: 8'(16 + 2*f + a)});
    while (req_q.size() > 0) step("R2");
    step("R2");

    // R3: a misfit in lane 1 stops lane 2 even though lane 2 would fit
    req_q.push_back('{fmt: 2'd0, an: 1'b1, pix: 8'd40});
    req_q.push_back('{fmt: 2'd2, an: 1'b1, pix: 8'd41});
    req_q.push_back('{fmt: 2'd0, an: 1'b0, pix: 8'd42});
    step("R3");
    step("R3");
    step("R3");
    step("R3");

    // R5/R6: random mixes with partly filled lane sets
    for (int cyc = 0; cyc < 400; cyc++) begin
      int add = $urandom_range(0, 3);
      for (int j = 0; j < add; j++) begin
        r.fmt = 2'($urandom_range(0, 3));
        r.an  = 1'($urandom_range(0, 1));
        r.pix = 8'($urandom_range(0, 255));
        if (req_q.size() < 12) req_q.push_back(r);
      end
      step("R5");
    end
    while (req_q.size() > 0) step("R6");
    step("R6");
    step("R6");

    // R8: an 8-unit request on the budget-4 instance spreads over two clocks
    @(negedge clk);
    b_valid = 4'b0011;
    b_fmt   = {4'b0, 2'd1, 2'd2};
    b_aniso = 4'b0001;
    b_pix   = {16'b0, 8'd6, 8'd5};
    #1;
    chk(b_take == 3'd1, "R8", "oversize grant count", 64'(b_take), 1);
    chk(b_ready == 1'b1, "R8", "ready before spread", 64'(b_ready), 1);
    @(negedge clk);
    b_valid = 4'b0001;
    b_fmt   = {6'b0, 2'd1};
    b_aniso = 4'b0000;
    b_pix   = {24'b0, 8'd6};
    #1;
    chk(b_ready == 1'b0, "R8", "ready during spread", 64'(b_ready), 0);
    chk(b_take == 3'd0, "R8", "grant during spread", 64'(b_take), 0);
    chk(b_svld == 4'hF, "R8", "first portion valid", 64'(b_svld), 64'hF);
    chk(b_spix == {4{8'd5}}, "R8", "first portion pixel", 64'(b_spix), 64'h05050505);
    chk(b_ssub == {3'd3, 3'd2, 3'd1, 3'd0}, "R8", "first portion sub",
        64'(b_ssub), 64'({3'd3, 3'd2, 3'd1, 3'd0}));
    @(negedge clk);
    #1;
    chk(b_svld == 4'hF, "R8", "second portion valid", 64'(b_svld), 64'hF);
    chk(b_spix == {4{8'd5}}, "R8", "second portion pixel", 64'(b_spix), 64'h05050505);
    chk(b_ssub == {3'd7, 3'd6, 3'd5, 3'd4}, "R8", "second portion sub",
        64'(b_ssub), 64'({3'd7, 3'd6, 3'd5, 3'd4}));
    chk(b_ready == 1'b1, "R8", "ready after spread", 64'(b_ready), 1);
    chk(b_take == 3'd1, "R8", "grant resumes", 64'(b_take), 1);
    @(negedge clk);
    b_valid = '0;
    #1;
    chk(b_svld == 4'b0011, "R8", "follow-up valid", 64'(b_svld), 64'h3);
    chk(b_spix[15:0] == {8'd6, 8'd6}, "R8", "follow-up pixel",
        64'(b_spix[15:0]), 64'h0606);
    chk(b_ssub[5:0] == {3'd1, 3'd0}, "R8", "follow-up sub",
        64'(b_ssub[5:0]), 64'({3'd1, 3'd0}));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule